// File: doc/BRIEF.md
# Programmable Interval Clock Counter

A register-mapped real-time clock for a processor bus. Software programs a 16-bit reload value, chooses a tick source, a counting direction and a mode, then sets the run bit. Each tick steps the counter by one. When the counter lands on zero, a done flag is set, or an overrun flag if done is still pending. An interrupt request can be raised, and the counter then either reloads from the buffer (repeat) or halts (single shot).

Three of the tick sources are derived inside the block from the system clock by parameterised prescalers: a 100 kHz tick, a 10 kHz tick and a line-frequency tick of 50 or 60 Hz. The fourth source is an external one-cycle trigger pulse. Register accesses have side effects on the flags and on the interrupt request, so the read of the status word serves as the interrupt acknowledge.

Top module: `prog_clock_counter`

## Requirements
- R1: After reset the control word, the buffer and the counter are zero and irq_o is low.
- R2: Word offsets: 0 is the control word, 2 is the buffer (reads as zero), 4 is the counter (read only, writes ignored); offset 6 reads zero. Control word bits: 0 run, 2:1 rate (00 fast 100 kHz, 01 10 kHz, 10 line, 11 external), 3 mode (1 repeat), 4 direction (1 up), 5 manual step (write only, reads 0), 6 interrupt enable, 7 done, 15 overrun; other bits read 0.
- R3: A full-word control write stores bits 0-4 and 6, clears done and overrun and drops irq_o.
- R4: A control read returns the current word, then clears done and overrun and drops irq_o from the next cycle.
- R5: A full-word buffer write loads the value into both buffer and counter, clears done and overrun and drops irq_o.
- R6: Each tick adds one (up) or subtracts one (down) modulo 2^16.
- R7: A tick giving zero sets overrun if done was already set, otherwise sets done, and raises irq_o when interrupt enable is set.
- R8: In repeat mode a tick giving zero reloads the counter from the buffer and run stays set.
- R9: In single-shot mode a tick giving zero clears the buffer and the run bit; the counter stays at zero.
- R10: A control write with run = 0 and bit 5 = 1 makes exactly one tick in that cycle using the newly written direction, mode and enable; with run = 1 bit 5 has no effect.
- R11: Source ticks step the counter only while run = 1; the fast source pulses every SYS_CLK_HZ/100000 cycles, the medium every SYS_CLK_HZ/10000, the line every SYS_CLK_HZ/LINE_HZ, the external one on each ext_tick_i pulse.
- R12: Writes without both byte enables, and any access with addr_i[0] = 1, have no effect.
- R13: A register write in the same cycle as a source tick wins and the tick is lost; a tick coinciding with a control read is applied after the read clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Byte address of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| be_i | input | 2 | Byte-lane enables of a write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of the address |
| ext_tick_i | input | 1 | External trigger, one pulse per tick |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives the counter across zero in both directions and at the 0xFFFF/0x0000 wrap, where a wrong modulo or a missed zero test would never set done. It lets a second zero arrive before the status is read, which a design without overrun logic would report as a plain done, and it makes a status read coincide with a tick to catch a design that loses the fresh done flag. Single-shot expiry is followed by a repeat-mode pass through zero, exposing a buffer that was not cleared, and manual steps are issued with run set to catch a design that steps anyway. Partial and odd-address writes must leave every register unchanged.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int DW = 16;
  localparam int AW = 3;

  localparam int WORD_CSR = 0;
  localparam int WORD_BUF = 1;
  localparam int WORD_CNT = 2;

  localparam int BIT_RUN     = 0;
  localparam int BIT_RATE_LO = 1;
  localparam int BIT_MODE    = 3;
  localparam int BIT_UP      = 4;
  localparam int BIT_STEP    = 5;
  localparam int BIT_IE      = 6;
  localparam int BIT_DONE    = 7;
  localparam int BIT_OVF     = 15;

  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_LINE = 2'd2,
    RATE_EXT  = 2'd3
  } rate_e;
endpackage

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R11: prescaler phase stays inside its period
  assert_div_in_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pclk_core.sv
module pclk_core
  import pclk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_wr_i,
  input  logic          buf_wr_i,
  input  logic          csr_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          src_tick_i,
  output rate_e         rate_o,
  output logic [DW-1:0] csr_o,
  output logic [DW-1:0] cnt_o,
  output logic          irq_o
);
  logic          run_q, run_d;
  rate_e         rate_q, rate_d;
  logic          rpt_q, rpt_d;
  logic          up_q, up_d;
  logic          ie_q, ie_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;
  logic          irq_q, irq_d;
  logic [DW-1:0] buf_q, buf_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          step;

  always_comb begin
    run_d  = run_q;  rate_d = rate_q; rpt_d = rpt_q; up_d = up_q; ie_d = ie_q;
    done_d = done_q; ovf_d  = ovf_q;  irq_d = irq_q;
    buf_d  = buf_q;  cnt_d  = cnt_q;
    step   = 1'b0;
    if (csr_wr_i) begin
      run_d  = wdata_i[BIT_RUN];
      rate_d = rate_e'(wdata_i[BIT_RATE_LO +: 2]);
      rpt_d  = wdata_i[BIT_MODE];
      up_d   = wdata_i[BIT_UP];
      ie_d   = wdata_i[BIT_IE];
      done_d = 1'b0; ovf_d = 1'b0; irq_d = 1'b0;
      step   = !wdata_i[BIT_RUN] && wdata_i[BIT_STEP];
    end else if (buf_wr_i) begin
      buf_d  = wdata_i;
      cnt_d  = wdata_i;
      done_d = 1'b0; ovf_d = 1'b0; irq_d = 1'b0;
    end else begin
      if (csr_rd_i) begin
        done_d = 1'b0; ovf_d = 1'b0; irq_d = 1'b0;
      end
      step = run_q && src_tick_i;
    end
    if (step) begin
      cnt_d = up_d ? cnt_q + 1'b1 : cnt_q - 1'b1;
      if (cnt_d == '0) begin
        if (done_d) ovf_d  = 1'b1;
        else        done_d = 1'b1;
        if (ie_d) irq_d = 1'b1;
        if (rpt_d) cnt_d = buf_d;
        else begin
          buf_d = '0;
          run_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; rate_q <= RATE_FAST; rpt_q <= 1'b0; up_q <= 1'b0; ie_q <= 1'b0;
      done_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0;
      buf_q <= '0; cnt_q <= '0;
    end else begin
      run_q <= run_d; rate_q <= rate_d; rpt_q <= rpt_d; up_q <= up_d; ie_q <= ie_d;
      done_q <= done_d; ovf_q <= ovf_d; irq_q <= irq_d;
      buf_q <= buf_d; cnt_q <= cnt_d;
    end
  end

  always_comb begin
    csr_o                   = '0;
    csr_o[BIT_RUN]          = run_q;
    csr_o[BIT_RATE_LO +: 2] = rate_q;
    csr_o[BIT_MODE]         = rpt_q;
    csr_o[BIT_UP]           = up_q;
    csr_o[BIT_IE]           = ie_q;
    csr_o[BIT_DONE]         = done_q;
    csr_o[BIT_OVF]          = ovf_q;
  end

  assign rate_o = rate_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  // R7: overrun only follows a pending done
  assert_ovf_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(done_q));

  // R3: plain control write leaves irq low
  assert_csr_wr_drops_irq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !(wdata_i[BIT_STEP] && !wdata_i[BIT_RUN])) |=> !irq_q);

  // R5: buffer write loads counter and clears flags
  assert_buf_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_i && !csr_wr_i) |=> (cnt_q == $past(wdata_i) && !done_q && !ovf_q && !irq_q));

  // R11: a stopped counter does not move without a write
  assert_stopped_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !csr_wr_i && !buf_wr_i) |=> $stable(cnt_q));

  // R9: run falling by itself leaves buffer and counter at zero
  assert_oneshot_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && $past(run_q) && !$past(csr_wr_i) && !$past(buf_wr_i)) |-> (buf_q == '0 && cnt_q == '0));
endmodule

// File: rtl/prog_clock_counter.sv
module prog_clock_counter
  import pclk_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 50_000_000,
  parameter int unsigned LINE_HZ    = 60,
  parameter int unsigned FAST_HZ    = 100_000,
  parameter int unsigned MID_HZ     = 10_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ext_tick_i,
  output logic          irq_o
);
  localparam int unsigned DIV_FAST = SYS_CLK_HZ / FAST_HZ;
  localparam int unsigned DIV_MID  = SYS_CLK_HZ / MID_HZ;
  localparam int unsigned DIV_LINE = SYS_CLK_HZ / LINE_HZ;

  logic [NUM_SRC-1:0] src_vec;
  logic [1:0]         word;
  logic               acc_ok, wr_full;
  logic               csr_wr, buf_wr, csr_rd;
  rate_e              rate;
  logic [DW-1:0]      csr_val, cnt_val;

  for (genvar g = 0; g < NUM_SRC - 1; g++) begin : g_div
    pclk_divider #(
      .DIV(g == 0 ? DIV_FAST : (g == 1 ? DIV_MID : DIV_LINE))
    ) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(src_vec[g])
    );
  end
  assign src_vec[NUM_SRC-1] = ext_tick_i;

  assign word    = addr_i[2:1];
  assign acc_ok  = !addr_i[0];
  assign wr_full = wr_i && acc_ok && (&be_i);
  assign csr_wr  = wr_full && (word == 2'(WORD_CSR));
  assign buf_wr  = wr_full && (word == 2'(WORD_BUF));
  assign csr_rd  = rd_i && acc_ok && (word == 2'(WORD_CSR));

  pclk_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csr_wr_i  (csr_wr),
    .buf_wr_i  (buf_wr),
    .csr_rd_i  (csr_rd),
    .wdata_i   (wdata_i),
    .src_tick_i(src_vec[rate]),
    .rate_o    (rate),
    .csr_o     (csr_val),
    .cnt_o     (cnt_val),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (acc_ok) begin
      if (word == 2'(WORD_CSR))      rdata_o = csr_val;
      else if (word == 2'(WORD_CNT)) rdata_o = cnt_val;
    end
  end

  // R12: partial or odd writes leave the configuration untouched
  assert_partial_wr_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_full) |=> $stable(csr_val[BIT_IE:BIT_RATE_LO]));

  // R2: step bit and unused bits never read back
  assert_csr_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_val[BIT_STEP] == 1'b0 && csr_val[14:8] == '0));
endmodule

// File: tb/prog_clock_counter_tb_top.sv
module prog_clock_counter_tb_top;
  localparam int unsigned SYS_HZ = 400_000;
  localparam int unsigned LN_HZ  = 50;
  localparam int D_FAST = SYS_HZ / 100_000;
  localparam int D_MID  = SYS_HZ / 10_000;
  localparam int D_LINE = SYS_HZ / LN_HZ;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, ext = 1'b0;
  logic [1:0]  be = 2'b11;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_checks = 0, n_err = 0;
  logic [15:0] smp;
  logic [15:0] exp_rd;

  // reference state
  logic m_run, m_rpt, m_up, m_ie, m_done, m_ovf, m_irq;
  logic [1:0]  m_rate;
  logic [15:0] m_buf, m_cnt;
  int cyc;

  prog_clock_counter #(.SYS_CLK_HZ(SYS_HZ), .LINE_HZ(LN_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .ext_tick_i(ext), .irq_o(irq));

  always #2 clk = ~clk;

  function automatic logic [15:0] m_csr();
    return {m_ovf, 7'b0, m_done, m_ie, 1'b0, m_up, m_rpt, m_rate, m_run};
  endfunction

  function automatic logic [15:0] m_read(logic [2:0] a);
    if (a[0]) return 16'h0;
    case (a[2:1])
      2'd0: return m_csr();
      2'd2: return m_cnt;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_rpt = 0; m_up = 0; m_ie = 0; m_done = 0; m_ovf = 0; m_irq = 0;
      m_rate = 0; m_buf = 0; m_cnt = 0; cyc = 0;
    end else begin
      logic full, tick, src;
      full = wr && (be == 2'b11) && !addr[0];
      tick = 0;
      case (m_rate)
        2'd0: src = (cyc % D_FAST) == D_FAST - 1;
        2'd1: src = (cyc % D_MID) == D_MID - 1;
        2'd2: src = (cyc % D_LINE) == D_LINE - 1;
        default: src = ext;
      endcase
      cyc++;
      if (full && addr[2:1] == 2'd0) begin
        m_run = wdata[0]; m_rate = wdata[2:1]; m_rpt = wdata[3]; m_up = wdata[4];
        m_ie = wdata[6]; m_done = 0; m_ovf = 0; m_irq = 0;
        tick = !wdata[0] && wdata[5];
      end else if (full && addr[2:1] == 2'd1) begin
        m_buf = wdata; m_cnt = wdata; m_done = 0; m_ovf = 0; m_irq = 0;
      end else begin
        if (rd && !addr[0] && addr[2:1] == 2'd0) begin m_done = 0; m_ovf = 0; m_irq = 0; end
        tick = m_run && src;
      end
      if (tick) begin
        m_cnt = m_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
        if (m_cnt == 0) begin
          if (m_done) m_ovf = 1; else m_done = 1;
          if (m_ie) m_irq = 1;
          if (m_rpt) m_cnt = m_buf;
          else begin m_buf = 0; m_run = 0; end
        end
      end
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // one bus cycle; called at a negative edge
  task automatic op(logic [2:0] a, logic w, logic r, logic [1:0] b, logic [15:0] d, logic e);
    addr = a; wr = w; rd = r; be = b; wdata = d; ext = e;
    #1;
    smp = rdata;
    exp_rd = m_read(a);
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0; ext = 0; be = 2'b11;
    check("R7 irq", {15'b0, irq}, {15'b0, m_irq});
  endtask

  task automatic wcsr(logic [15:0] d); op(3'd0, 1, 0, 2'b11, d, 0); endtask
  task automatic wbuf(logic [15:0] d); op(3'd2, 1, 0, 2'b11, d, 0); endtask
  task automatic pulse(); op(3'd6, 0, 0, 2'b11, 0, 1); endtask
  task automatic rchk(logic [2:0] a, logic [15:0] expv, string req);
    op(a, 0, 1, 2'b11, 0, 0);
    check(req, smp, expv);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    rchk(3'd0, 16'h0000, "R1 csr");
    rchk(3'd4, 16'h0000, "R1 counter");
    // R2 map, R5 load
    wbuf(16'h1234);
    rchk(3'd2, 16'h0000, "R2 buffer reads zero");
    rchk(3'd4, 16'h1234, "R5 counter loaded");
    op(3'd4, 1, 0, 2'b11, 16'h5555, 0);
    rchk(3'd4, 16'h1234, "R2 counter write ignored");
    rchk(3'd6, 16'h0000, "R2 offset 6");
    // R3 writable mask, ext source idle
    wcsr(16'hFFFF);
    rchk(3'd0, 16'h005F, "R3 write mask");
    wcsr(16'h0000);
    // R10 manual steps, R7 done + irq, R4 read clear
    wbuf(16'h0002);
    wcsr(16'h0060);
    rchk(3'd4, 16'h0001, "R10 manual step");
    wcsr(16'h0060);
    check("R7 irq on zero", {15'b0, irq}, 16'h1);
    rchk(3'd0, 16'h00C0, "R4 read returns done");
    check("R4 irq dropped", {15'b0, irq}, 16'h0);
    rchk(3'd0, 16'h0040, "R4 done cleared");
    // R7 overrun, R8 repeat
    wbuf(16'h0001);
    wcsr(16'h000F);
    pulse(); pulse();
    rchk(3'd0, 16'h808F, "R7 overrun");
    rchk(3'd4, 16'h0001, "R8 reload");
    // R13 tick during control read
    pulse();
    op(3'd0, 0, 1, 2'b11, 0, 1);
    check("R13 read value", smp, 16'h008F);
    rchk(3'd0, 16'h008F, "R13 fresh done kept");
    // R6 up wrap, R8
    wbuf(16'hFFFE);
    wcsr(16'h005F);
    pulse();
    rchk(3'd4, 16'hFFFF, "R6 up step");
    pulse();
    check("R7 irq up wrap", {15'b0, irq}, 16'h1);
    rchk(3'd4, 16'hFFFE, "R8 reload after wrap");
    // R9 single shot
    wbuf(16'h0002);
    wcsr(16'h0007);
    pulse(); pulse();
    rchk(3'd0, 16'h0086, "R9 run cleared");
    pulse();
    rchk(3'd4, 16'h0000, "R11 stopped ignores ticks");
    wcsr(16'h000F); pulse();
    rchk(3'd4, 16'hFFFF, "R6 down wrap");
    wcsr(16'h001F); pulse();
    rchk(3'd4, 16'h0000, "R9 buffer was cleared");
    // R10 step ignored while running
    wcsr(16'h0000);
    wbuf(16'h0005);
    wcsr(16'h0027);
    rchk(3'd4, 16'h0005, "R10 step ignored when running");
    // R13 write beats tick
    op(3'd2, 1, 0, 2'b11, 16'h0009, 1);
    rchk(3'd4, 16'h0009, "R13 write wins");
    // R12 partial and odd writes
    op(3'd0, 1, 0, 2'b01, 16'h0058, 0);
    rchk(3'd0, 16'h0007, "R12 low lane csr");
    op(3'd2, 1, 0, 2'b10, 16'h0100, 0);
    rchk(3'd4, 16'h0009, "R12 high lane buffer");
    op(3'd3, 1, 0, 2'b11, 16'h0100, 0);
    rchk(3'd4, 16'h0009, "R12 odd address");
    // R11 fast source timing
    wbuf(16'h0100);
    wcsr(16'h0001);
    repeat (40) op(3'd6, 0, 0, 2'b11, 0, 0);
    wcsr(16'h0000);
    rchk(3'd4, m_cnt, "R11 fast source");
    check("R11 fast count moved", {15'b0, (m_cnt < 16'h0100 - 16'd8)}, 16'h1);
    // random mix against reference
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] v;
      logic e;
      sel = $urandom % 16;
      e = ($urandom % 4) == 0;
      case (sel)
        0, 1: begin
          v = 16'($urandom) & 16'h807F;
          if ($urandom % 3 != 0) v[2:1] = ($urandom % 2) ? 2'b11 : 2'b00;
          op(3'd0, 1, 0, 2'b11, v, e);
        end
        2: begin
          v = ($urandom % 2) ? 16'($urandom % 6) : 16'hFFFF - 16'($urandom % 6);
          op(3'd2, 1, 0, 2'b11, v, e);
        end
        3, 4: begin op(3'd0, 0, 1, 2'b11, 0, e); check("R4 random csr read", smp, exp_rd); end
        5, 6: begin op(3'd4, 0, 1, 2'b11, 0, e); check("R6 random counter read", smp, exp_rd); end
        7: op(3'(($urandom % 4) * 2), 1, 0, 2'($urandom % 3), 16'($urandom), e);
        8: begin op(3'd2, 0, 1, 2'b11, 0, e); check("R2 random buffer read", smp, exp_rd); end
        default: op(3'd6, 0, 0, 2'b11, 0, e);
      endcase
    end
    rchk(3'd0, m_csr(), "R3 final csr");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule